// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns three reset causes into one processor reset that is held long enough for the system to settle. The three causes are a digital power-fail flag, an active-low push-button line and a single-cycle request from a watchdog. The push-button line comes from outside the clock domain. It is synchronized first and then accepted only after it has stayed low for a set number of millisecond ticks. A short bounce or brief tap therefore has no effect.

When every cause has gone away, the reset is stretched. It stays asserted for a fixed number of millisecond ticks, counted from the moment the last cause ended. If a new cause appears during the stretch, the count starts again when that cause ends. All timing runs on a one-cycle `tick_1ms` enable derived from the system clock, so the clock frequency does not affect the timing. The block drives an active-low reset and its active-high complement. After the block's own synchronous reset, the output is asserted and the block behaves as if power had just returned.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst` is high, `rst_o` is 1. After `rst` falls, `rst_o` stays 1 through STRETCH_MS-1 ticks and drops on the STRETCH_MS-th tick (default 250).
- R2: `rst_o` is 1 in every cycle in which `pwr_fail` is 1, with no cycle of delay.
- R3: After `pwr_fail` returns to 0, `rst_o` stays 1 through STRETCH_MS-1 ticks, counted from the clearing, and drops on the STRETCH_MS-th tick.
- R4: `pb_n` is active low and passes through a two-flop synchronizer. Once the synchronized level is low, `rst_o` rises just after the QUAL_MS-th tick (default 40) of continuous low, and not earlier.
- R5: If `pb_n` returns high before QUAL_MS ticks of low, no reset is issued and the qualification count clears. A later short press starts counting from zero.
- R6: After a qualified press, `rst_o` stays 1 while `pb_n` is held low. From the release it stays 1 through STRETCH_MS-1 ticks and drops on the STRETCH_MS-th tick.
- R7: A one-cycle `wd_req` pulse makes `rst_o` 1 in that same cycle and holds it for STRETCH_MS ticks after the pulse.
- R8: A cause that appears while the reset is being stretched restarts the stretch count. Release then needs a full STRETCH_MS ticks after that cause ends.
- R9: `rst_n_o` is always the exact inverse of `rst_o`.
- R10: Only cycles with `tick_1ms` high advance the qualification and stretch counts. Without ticks, an asserted reset never releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the logic |
| tick_1ms | input | 1 | One-cycle enable, once per millisecond |
| pwr_fail | input | 1 | Power-fail flag, active high, synchronous to clk |
| pb_n | input | 1 | Push-button, active low, asynchronous |
| wd_req | input | 1 | Watchdog reset request, one-cycle pulse |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The assertions assume that `pwr_fail` and `wd_req` are already synchronous to `clk`. They also assume that `tick_1ms` is a single-cycle pulse and never stays high across two edges. The minimum-stretch check counts only power-fail and watchdog activity. This holds because a qualified push-button can only lengthen the reset, never shorten it. The bench drives every input on the falling edge and issues each tick as a one-cycle pulse followed by seven idle cycles. It waits three cycles after each change of `pb_n` before the next tick, so the synchronizer delay never shifts the tick count.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

    // Reset causes gathered in one bundle
    typedef struct packed {
        logic pwr;
        logic pb;
        logic wd;
    } cause_t;

    // Stretch engine state
    typedef enum logic {
        STR_IDLE = 1'b0,
        STR_HOLD = 1'b1
    } stretch_state_t;

    // Counter width able to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic cause_any(input cause_t c);
        return c.pwr | c.pb | c.wd;
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int STAGES = 2,
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= IDLE;
                else if (i == 0)
                    chain[i] <= d_async;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/supv_pb_qual.sv
module supv_pb_qual
    import supv_reset_pkg::*;
#(
    parameter int QUAL_MS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pb_low,
    output logic pb_held
);
    localparam int QW = cnt_width(QUAL_MS);
    localparam logic [QW-1:0] LAST = QW'(QUAL_MS - 1);

    logic [QW-1:0] low_cnt;
    logic          held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            held_q  <= 1'b0;
        end else if (!pb_low) begin
            low_cnt <= '0;
            held_q  <= 1'b0;
        end else if (tick && !held_q) begin
            if (low_cnt == LAST) begin
                held_q <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign pb_held = held_q;
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
    import supv_reset_pkg::*;
#(
    parameter int STRETCH_MS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cause,
    output logic holding
);
    localparam int SW = cnt_width(STRETCH_MS);
    localparam logic [SW-1:0] LAST = SW'(STRETCH_MS - 1);

    stretch_state_t state;
    logic [SW-1:0]  ms_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= STR_HOLD;   // behave as if power had just returned
            ms_cnt <= '0;
        end else if (cause) begin
            state  <= STR_HOLD;
            ms_cnt <= '0;
        end else if (state == STR_HOLD && tick) begin
            if (ms_cnt == LAST) begin
                state  <= STR_IDLE;
                ms_cnt <= '0;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

    assign holding = (state == STR_HOLD);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_reset_pkg::*;
#(
    parameter int QUAL_MS     = 40,
    parameter int STRETCH_MS  = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1ms,
    input  logic pwr_fail,
    input  logic pb_n,
    input  logic wd_req,
    output logic rst_n_o,
    output logic rst_o
);
    logic   pb_n_s;
    logic   pb_held;
    logic   holding;
    cause_t cause;
    logic   active;

    supv_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pb_n),
        .q_sync  (pb_n_s)
    );

    supv_pb_qual #(.QUAL_MS(QUAL_MS)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .pb_low  (!pb_n_s),
        .pb_held (pb_held)
    );

    always_comb begin
        cause.pwr = pwr_fail;
        cause.pb  = pb_held;
        cause.wd  = wd_req;
    end

    supv_stretch #(.STRETCH_MS(STRETCH_MS)) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .cause   (cause_any(cause)),
        .holding (holding)
    );

    assign active  = holding | cause_any(cause);
    assign rst_o   = active;
    assign rst_n_o = ~active;
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
    parameter int QUAL_MS    = 40,
    parameter int STRETCH_MS = 250
) (
    input logic clk,
    input logic rst,
    input logic tick_1ms,
    input logic pwr_fail,
    input logic wd_req,
    input logic rst_n_o,
    input logic rst_o
);
    localparam int CW = (STRETCH_MS < 2) ? 1 : $clog2(STRETCH_MS + 1);

    // Ticks seen since the last power-fail or watchdog cause, saturating
    logic [CW-1:0] since_cause;

    always_ff @(posedge clk) begin
        if (rst || pwr_fail || wd_req)
            since_cause <= '0;
        else if (tick_1ms && since_cause < CW'(STRETCH_MS))
            since_cause <= since_cause + 1'b1;
    end

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) rst_n_o == ~rst_o) // R9
        else $error("outputs not complementary");
    AST_PF_AT_ONCE: assert property (@(posedge clk) disable iff (rst) pwr_fail |-> rst_o) // R2
        else $error("power fail without reset");
    AST_WD_AT_ONCE: assert property (@(posedge clk) disable iff (rst) wd_req |-> rst_o) // R7
        else $error("watchdog request without reset");
    AST_NO_TICK_NO_RELEASE: assert property (@(posedge clk) disable iff (rst) (rst_o && !tick_1ms) |=> rst_o) // R10
        else $error("reset released without a tick");
    AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (rst) $fell(rst_o) |-> since_cause >= CW'(STRETCH_MS)) // R3
        else $error("reset released too early");
endmodule

bind supv_reset_gen supv_reset_gen_chk #(
    .QUAL_MS    (QUAL_MS),
    .STRETCH_MS (STRETCH_MS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1ms (tick_1ms),
    .pwr_fail (pwr_fail),
    .wd_req   (wd_req),
    .rst_n_o  (rst_n_o),
    .rst_o    (rst_o)
);

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;
    localparam int QUAL    = 40;
    localparam int STRETCH = 250;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic pwr_fail = 1'b0;
    logic pb_n = 1'b1;
    logic wd_req = 1'b0;
    logic rst_n_o, rst_o;

    int checks = 0;
    int failures = 0;

    supv_reset_gen #(.QUAL_MS(QUAL), .STRETCH_MS(STRETCH)) dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .pwr_fail(pwr_fail),
        .pb_n(pb_n), .wd_req(wd_req), .rst_n_o(rst_n_o), .rst_o(rst_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic exp);
        checks++;
        if (rst_o !== exp || rst_n_o !== ~exp) begin
            failures++;
            $display("FAIL %s: rst_o=%b rst_n_o=%b expected rst_o=%b", req, rst_o, rst_n_o, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            repeat (7) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: logic reset asserts output, then stretch of STRETCH ticks
    task automatic t_reset();
        idle(4);
        chk("R1 in reset", 1'b1);
        rst = 1'b0;
        idle(20);
        chk("R10 no ticks keeps reset", 1'b1);
        ticks(STRETCH - 1);
        chk("R1 before last tick", 1'b1);
        ticks(1);
        chk("R1 released", 1'b0);
    endtask

    // R2, R3: power fail immediate, stretch from clearing
    task automatic t_pwr();
        pwr_fail = 1'b1;
        #1 chk("R2 immediate", 1'b1);
        idle(1);
        ticks(300);
        chk("R2 held during fail", 1'b1);
        pwr_fail = 1'b0;
        idle(2);
        ticks(STRETCH - 1);
        chk("R3 before last tick", 1'b1);
        ticks(1);
        chk("R3 released", 1'b0);
    endtask

    // R5: short presses are ignored and the count clears
    task automatic t_short();
        pb_n = 1'b0;
        idle(3);
        ticks(QUAL - 1);
        chk("R5 short press", 1'b0);
        pb_n = 1'b1;
        idle(3);
        ticks(5);
        chk("R5 after short release", 1'b0);
        pb_n = 1'b0;
        idle(3);
        ticks(QUAL - 1);
        chk("R5 count cleared", 1'b0);
        pb_n = 1'b1;
        idle(3);
        ticks(2);
        chk("R5 still idle", 1'b0);
    endtask

    // R4, R6: qualified press, stretch from release
    task automatic t_long();
        pb_n = 1'b0;
        idle(3);
        ticks(QUAL - 1);
        chk("R4 one tick short", 1'b0);
        ticks(1);
        chk("R4 qualified", 1'b1);
        ticks(400);
        chk("R6 held while pressed", 1'b1);
        pb_n = 1'b1;
        idle(4);
        ticks(STRETCH - 1);
        chk("R6 before last tick", 1'b1);
        ticks(1);
        chk("R6 released", 1'b0);
    endtask

    // R7: watchdog pulse
    task automatic t_wd();
        wd_req = 1'b1;
        #1 chk("R7 immediate", 1'b1);
        @(negedge clk);
        wd_req = 1'b0;
        idle(2);
        chk("R7 stretched", 1'b1);
        ticks(STRETCH - 1);
        chk("R7 before last tick", 1'b1);
        ticks(1);
        chk("R7 released", 1'b0);
    endtask

    // R8: retrigger during stretch restarts the count
    task automatic t_retrig();
        pwr_fail = 1'b1;
        idle(2);
        pwr_fail = 1'b0;
        idle(1);
        ticks(100);
        chk("R8 mid stretch", 1'b1);
        wd_req = 1'b1;
        @(negedge clk);
        wd_req = 1'b0;
        idle(1);
        ticks(STRETCH - 1);
        chk("R8 restarted count", 1'b1);
        ticks(1);
        chk("R8 released", 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pwr();
        t_short();
        t_long();
        t_wd();
        t_retrig();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule